// File: doc/BRIEF.md
# Double-Buffered BCD Calendar Clock

This block is a real-time clock and calendar core. A one-cycle tick strobe, one per second, advances a chain of running BCD counters for seconds, minutes, 24-hour hours, day of week, day of month, month, year and century. Month lengths, February in leap years and the turn of the century are all handled inside the counter chain.

Software never touches the running counters directly. It sees a separate bank of user registers in a 16-entry window at the top of a small synchronous register bus. When neither control flag is set, that bank follows the counters one cycle behind. A freeze flag holds the bank steady so that a multi-byte read stays coherent while time keeps running underneath. A set flag stops the copying and opens the time registers to writes. Clearing the set flag loads the written base time into the counters. An oscillator-stop bit masks the tick. A sticky oscillator-fault flag records a dead oscillator found at power-up.

The bus is plain and carries no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read sampled with `bus_rd` high returns its data on `bus_rdata` after that same edge, and the value is held until the next read.

Top module: `rtc_bcd_clock`

## Requirements
- R1: The register window is the 16 addresses whose upper address bits are all ones. Offset 0x0 is the control/status register, 0x8 the oscillator register, 0x9 seconds, 0xA minutes, 0xB hours, 0xC day of week, 0xD date, 0xE month, 0xF year and 0x1 century. Reads of any other offset, and of any address outside the window, return 0x00.
- R2: Each unmasked tick advances seconds. Seconds and minutes wrap from 0x59 to 0x00 and carry on. Hours wrap from 0x23 to 0x00 and carry on.
- R3: A day carry advances day of week, which runs 0x01 to 0x07 and back to 0x01. It also advances the date, which wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, after 0x31 in the other months, and after February's last day. Month wraps from 0x12 to 0x01 and carries into the year.
- R4: February ends at 0x29 when the year is a multiple of four. For year 0x00, the century must be a multiple of four instead. Otherwise February ends at 0x28. Year wraps from 0x99 to 0x00 and advances the century.
- R5: While the freeze flag (control bit 1) is 1, the user time registers hold their values. The counters keep advancing.
- R6: After the freeze flag is written to 0, every user time register shows the counter value from the second clock edge after the write onward.
- R7: While the set flag (control bit 0) is 1, writes to the time registers are accepted and the user registers are not refreshed from the counters. While the set flag is 0, writes to the time registers have no effect.
- R8: On the edge after the set flag is written from 1 to 0, the counters load the user register values. Counting resumes from that base time.
- R9: A counter digit written with a non-BCD value keeps incrementing up to 0xF, then wraps to 0x0 with a carry into the next digit, and counts normally after that. A field holding a value above its maximum gives no carry to the next field until it next passes its maximum.
- R10: Oscillator register bit 7 is the stop bit. While it is 1, ticks are ignored and the counters hold.
- R11: The oscillator-fault flag (control bit 2) is set in the first cycle after reset when the stop bit is 0 and `osc_active` is low. It stays set until software writes 0 to bit 2. Writing 1 to bit 2 has no effect.
- R12: Reset gives: control 0x00, oscillator register 0x00, time 00:00:00, day of week 0x01, date 0x01, month 0x01, year 0x00, century 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe per second |
| osc_active | input | 1 | Oscillator activity indication, sampled after reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |

## Verification
The bound checker watches the seconds path on every cycle. It confirms that the freeze and set flags keep the user copy still, that a stop bit of 1 holds the counters, that a set-flag release loads the user value, that 59 seconds wraps to 00, and that the fault flag stays set until it is cleared. The bench's scenarios are the only evidence for the calendar behaviour: carries through month lengths, the leap-year and century rules, the non-BCD digit path, address decoding, and the power-up fault detection.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_FIELDS = 8;
  localparam int FLD_SEC   = 0;
  localparam int FLD_MIN   = 1;
  localparam int FLD_HOUR  = 2;
  localparam int FLD_DOW   = 3;
  localparam int FLD_DATE  = 4;
  localparam int FLD_MONTH = 5;
  localparam int FLD_YEAR  = 6;
  localparam int FLD_CENT  = 7;

  typedef logic [NUM_FIELDS-1:0][7:0] field_vec_t;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_OSC  = 4'h8;

  function automatic logic [3:0] field_off(input int i);
    case (i)
      FLD_SEC:   return 4'h9;
      FLD_MIN:   return 4'hA;
      FLD_HOUR:  return 4'hB;
      FLD_DOW:   return 4'hC;
      FLD_DATE:  return 4'hD;
      FLD_MONTH: return 4'hE;
      FLD_YEAR:  return 4'hF;
      default:   return 4'h1;
    endcase
  endfunction

  function automatic logic [7:0] field_min(input int i);
    case (i)
      FLD_DOW, FLD_DATE, FLD_MONTH: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] field_rst(input int i);
    if (i == FLD_CENT) return 8'h20;
    return field_min(i);
  endfunction

  function automatic logic [7:0] field_max(input int i);
    case (i)
      FLD_SEC, FLD_MIN: return 8'h59;
      FLD_HOUR:         return 8'h23;
      FLD_DOW:          return 8'h07;
      FLD_DATE:         return 8'h31;
      FLD_MONTH:        return 8'h12;
      default:          return 8'h99;
    endcase
  endfunction

  // field whose wrap carries into field i (field 0 is driven by the tick)
  function automatic int field_src(input int i);
    case (i)
      FLD_DOW, FLD_DATE: return FLD_HOUR;
      FLD_MONTH:         return FLD_DATE;
      default:           return (i > 0) ? i - 1 : 0;
    endcase
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v,
                                          input logic [7:0] maxv,
                                          input logic [7:0] minv);
    logic [3:0] hi, lo;
    hi = v[7:4];
    lo = v[3:0];
    if (v == maxv) return minv;
    if (lo == 4'h9 || lo == 4'hF) return {hi + 4'h1, 4'h0};
    return {hi, lo + 4'h1};
  endfunction

  function automatic logic bcd_div4(input logic [7:0] b);
    if (b[4]) return (b[3:0] == 4'h2) || (b[3:0] == 4'h6);
    return (b[3:0] == 4'h0) || (b[3:0] == 4'h4) || (b[3:0] == 4'h8);
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] month,
                                                input logic [7:0] year,
                                                input logic [7:0] cent);
    logic leap;
    leap = (year == 8'h00) ? bcd_div4(cent) : bcd_div4(year);
    case (month)
      8'h02: return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
  import rtc_pkg::*;
#(
  parameter logic [7:0] MIN_VAL = 8'h00,
  parameter logic [7:0] RST_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic [7:0] max_val,
  output logic [7:0] val,
  output logic       wrap
);
  assign wrap = step && (val == max_val);

  always_ff @(posedge clk) begin
    if (!rst_n)    val <= RST_VAL;
    else if (load) val <= load_val;
    else if (step) val <= bcd_step(val, max_val, MIN_VAL);
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       load,
  input  field_vec_t load_vals,
  output field_vec_t cnt_vals
);
  field_vec_t            max_vec;
  logic [NUM_FIELDS-1:0] wrap;
  logic [NUM_FIELDS-1:0] step_in;

  always_comb begin
    for (int i = 0; i < NUM_FIELDS; i++) max_vec[i] = field_max(i);
    max_vec[FLD_DATE] = month_last_day(cnt_vals[FLD_MONTH], cnt_vals[FLD_YEAR],
                                       cnt_vals[FLD_CENT]);
  end

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
    if (i == 0) begin : g_head
      assign step_in[i] = tick_en;
    end else begin : g_chain
      assign step_in[i] = wrap[field_src(i)];
    end
    rtc_bcd_field #(.MIN_VAL(field_min(i)), .RST_VAL(field_rst(i))) u_fld (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step_in[i]),
      .load     (load),
      .load_val (load_vals[i]),
      .max_val  (max_vec[i]),
      .val      (cnt_vals[i]),
      .wrap     (wrap[i])
    );
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              osc_active,
  input  field_vec_t        cnt_vals,
  output field_vec_t        usr_vals,
  output logic              load,
  output logic              oscen,
  output logic              oscf,
  output logic              flag_r,
  output logic              flag_w
);
  localparam int HI_W = ADDR_W - 4;

  logic       in_win, wr_hit, snap_en, w_prev, chk_pend;
  logic [3:0] off;
  logic [7:0] rd_mux;

  assign in_win  = &bus_addr[ADDR_W-1:ADDR_W-HI_W];
  assign off     = bus_addr[3:0];
  assign wr_hit  = bus_wr && in_win;
  assign load    = w_prev && !flag_w;
  assign snap_en = !flag_w && !flag_r && !load;

  for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_usr
    always_ff @(posedge clk) begin
      if (!rst_n)                                     usr_vals[i] <= field_rst(i);
      else if (wr_hit && flag_w && off == field_off(i)) usr_vals[i] <= bus_wdata;
      else if (snap_en)                               usr_vals[i] <= cnt_vals[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_w   <= 1'b0;
      flag_r   <= 1'b0;
      oscf     <= 1'b0;
      oscen    <= 1'b0;
      w_prev   <= 1'b0;
      chk_pend <= 1'b1;
    end else begin
      w_prev <= flag_w;
      if (wr_hit && off == OFF_CTRL) begin
        flag_w <= bus_wdata[0];
        flag_r <= bus_wdata[1];
        if (!bus_wdata[2]) oscf <= 1'b0;
      end
      if (wr_hit && off == OFF_OSC) oscen <= bus_wdata[7];
      if (chk_pend) begin
        chk_pend <= 1'b0;
        if (!oscen && !osc_active) oscf <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    if (in_win) begin
      case (off)
        OFF_CTRL: rd_mux = {5'b0, oscf, flag_r, flag_w};
        OFF_OSC:  rd_mux = {oscen, 7'b0};
        default: begin
          for (int i = 0; i < NUM_FIELDS; i++)
            if (off == field_off(i)) rd_mux = usr_vals[i];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= 8'h00;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              osc_active,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  field_vec_t cnt_vals, usr_vals;
  logic       load, oscen, oscf, flag_r, flag_w, tick_en;
  logic [7:0] cnt_sec, usr_sec;

  assign tick_en = tick_1hz && !oscen;
  assign cnt_sec = cnt_vals[FLD_SEC];
  assign usr_sec = usr_vals[FLD_SEC];

  rtc_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .osc_active (osc_active),
    .cnt_vals   (cnt_vals),
    .usr_vals   (usr_vals),
    .load       (load),
    .oscen      (oscen),
    .oscf       (oscf),
    .flag_r     (flag_r),
    .flag_w     (flag_w)
  );

  rtc_calendar u_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .load      (load),
    .load_vals (usr_vals),
    .cnt_vals  (cnt_vals)
  );
endmodule

// File: rtl/rtc_bcd_clock_chk.sv
module rtc_bcd_clock_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              load,
  input logic              oscen,
  input logic              oscf,
  input logic              flag_r,
  input logic              flag_w,
  input logic [7:0]        cnt_sec,
  input logic [7:0]        usr_sec
);
  logic ctrl_wr;
  assign ctrl_wr = bus_wr && (&bus_addr[ADDR_W-1:4]) && (bus_addr[3:0] == 4'h0);

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !oscen && !load && cnt_sec == 8'h59) |=> (cnt_sec == 8'h00));

  p_freeze_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_r && !bus_wr) |=> $stable(usr_sec));

  p_set_shield_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w && !bus_wr) |=> $stable(usr_sec));

  p_base_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_sec == $past(usr_sec)));

  p_osc_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oscen && !load) |=> $stable(cnt_sec));

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (oscf && !ctrl_wr) |=> oscf);
endmodule

bind rtc_bcd_clock rtc_bcd_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_1hz (tick_1hz),
  .bus_addr (bus_addr),
  .bus_wr   (bus_wr),
  .load     (load),
  .oscen    (oscen),
  .oscf     (oscf),
  .flag_r   (flag_r),
  .flag_w   (flag_w),
  .cnt_sec  (cnt_sec),
  .usr_sec  (usr_sec)
);

// File: tb/tb_rtc_bcd_clock.sv
module tb_rtc_bcd_clock;
  localparam int ADDR_W = 8;
  localparam logic [7:0] A_CTRL = 8'hF0, A_CENT = 8'hF1, A_OSC = 8'hF8,
    A_SEC = 8'hF9, A_MIN = 8'hFA, A_HOUR = 8'hFB, A_DOW = 8'hFC,
    A_DATE = 8'hFD, A_MON = 8'hFE, A_YEAR = 8'hFF;

  logic clk = 1'b0, rst_n = 1'b0, tick_1hz = 1'b0, osc_active = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;

  int checks = 0, failures = 0, cyc = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rtc_bcd_clock #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_active(osc_active),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always @(posedge clk) begin
    rd_seen <= bus_rd;
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor: compare each read result against the scoreboard
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks = checks + 1;
      if (bus_rdata !== e) begin
        failures = failures + 1;
        $display("FAIL %s: actual %02h expected %02h", t, bus_rdata, e);
      end
    end
  end

  task automatic do_reset(input logic osc);
    @(negedge clk);
    osc_active = osc;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] ce, yr, mo, dt, dw, hr, mn, sc);
    wr(A_CTRL, 8'h01);
    wr(A_CENT, ce); wr(A_YEAR, yr); wr(A_MON, mo); wr(A_DATE, dt);
    wr(A_DOW, dw);  wr(A_HOUR, hr); wr(A_MIN, mn); wr(A_SEC, sc);
    wr(A_CTRL, 8'h00);
    idle(2);
  endtask

  initial begin
    do_reset(1'b1);
    // R12 reset state
    rd_chk(A_CTRL, 8'h00, "R12");
    rd_chk(A_OSC,  8'h00, "R12");
    rd_chk(A_SEC,  8'h00, "R12");
    rd_chk(A_DOW,  8'h01, "R12");
    rd_chk(A_MON,  8'h01, "R12");
    rd_chk(A_CENT, 8'h20, "R12");

    // R8 base time load, R1 decode, R2/R3/R4 full rollover
    set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h58);
    rd_chk(A_SEC,  8'h58, "R8");
    rd_chk(8'h79,  8'h00, "R1");
    rd_chk(8'hF5,  8'h00, "R1");
    tick(2);
    rd_chk(A_SEC,  8'h00, "R2");
    rd_chk(A_MIN,  8'h00, "R2");
    rd_chk(A_HOUR, 8'h00, "R2");
    rd_chk(A_DOW,  8'h01, "R3");
    rd_chk(A_DATE, 8'h01, "R3");
    rd_chk(A_MON,  8'h01, "R3");
    rd_chk(A_YEAR, 8'h00, "R4");
    rd_chk(A_CENT, 8'h21, "R4");

    // R4 leap rules
    set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(1);
    rd_chk(A_DATE, 8'h29, "R4");
    rd_chk(A_MON,  8'h02, "R4");
    set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(1);
    rd_chk(A_DATE, 8'h01, "R4");
    rd_chk(A_MON,  8'h03, "R4");
    set_time(8'h19, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(1);
    rd_chk(A_DATE, 8'h01, "R4");
    set_time(8'h20, 8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    tick(1);
    rd_chk(A_DATE, 8'h29, "R4");

    // R3 thirty-day month
    set_time(8'h20, 8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    tick(1);
    rd_chk(A_DATE, 8'h01, "R3");
    rd_chk(A_MON,  8'h05, "R3");
    rd_chk(A_DOW,  8'h03, "R3");

    // R5 freeze, R6 refresh
    set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h03, 8'h12, 8'h00, 8'h10);
    wr(A_CTRL, 8'h02);
    tick(3);
    rd_chk(A_SEC,  8'h10, "R5");
    wr(A_CTRL, 8'h00);
    rd_chk(A_SEC,  8'h13, "R6");

    // R7 write shield and ignored writes, R8 resume from base
    wr(A_SEC, 8'h45);
    rd_chk(A_SEC,  8'h13, "R7");
    wr(A_CTRL, 8'h01);
    wr(A_SEC, 8'h30);
    tick(2);
    rd_chk(A_SEC,  8'h30, "R7");
    wr(A_CTRL, 8'h00);
    idle(2);
    rd_chk(A_SEC,  8'h30, "R8");
    tick(1);
    rd_chk(A_SEC,  8'h31, "R8");

    // R9 non-BCD digits
    set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h03, 8'h10, 8'h20, 8'h5E);
    tick(1);
    rd_chk(A_SEC,  8'h5F, "R9");
    tick(1);
    rd_chk(A_SEC,  8'h60, "R9");
    set_time(8'h20, 8'h24, 8'h05, 8'h10, 8'h03, 8'h10, 8'h20, 8'hF9);
    tick(1);
    rd_chk(A_SEC,  8'h00, "R9");
    rd_chk(A_MIN,  8'h20, "R9");

    // R10 oscillator stop
    wr(A_OSC, 8'h80);
    rd_chk(A_OSC,  8'h80, "R10");
    tick(3);
    rd_chk(A_SEC,  8'h00, "R10");
    wr(A_OSC, 8'h00);
    tick(1);
    rd_chk(A_SEC,  8'h01, "R10");

    // R11 oscillator fault flag
    wr(A_CTRL, 8'h04);
    rd_chk(A_CTRL, 8'h00, "R11");
    do_reset(1'b0);
    rd_chk(A_CTRL, 8'h04, "R11");
    wr(A_CTRL, 8'h04);
    rd_chk(A_CTRL, 8'h04, "R11");
    wr(A_CTRL, 8'h00);
    rd_chk(A_CTRL, 8'h00, "R11");

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule